// File: doc/BRIEF.md
# Configurable I2S Transmit Serializer

The block turns stereo audio sample pairs into a serial stream. The upstream logic writes each pair into a small internal FIFO over a valid/ready handshake. The pair holds a left and a right sample, each right-aligned in a `SLOT_BITS`-wide word. A frame has two slots of `SLOT_BITS` bit periods each. The serializer sends one bit on every clock cycle where the bit-clock enable `bck_en` is high, most significant bit first. It drives the data line `sd_out` and the word-select line `ws_out`, and `sclk_run` tells the pad logic whether the bit clock should toggle.

Several options are chosen at run time and take effect at the next frame boundary:
- the sample width;
- which channel goes first;
- a one-bit delay of the MSB after the word-select edge;
- a one-bit frame-sync pulse in place of a 50 % word select;
- five channel/slot modes;
- whether the bus halts or sends silence when the FIFO runs dry.

A synchronous transmit reset `tx_rst` clears the serializer and flushes the FIFO. The `tx_start` level enables shifting.

The controller has three states:
- `S_IDLE`: not shifting, outputs low.
- `S_RUN`: bits are shifted.
- `S_HALT`: the bus is parked because the FIFO is empty.

It moves between them as follows:
- `S_IDLE` → `S_RUN` when `tx_start` is high.
- `S_RUN` → `S_IDLE` when `tx_start` drops.
- `S_RUN` → `S_HALT` at a frame start that finds the FIFO empty while halting is selected.
- `S_HALT` → `S_RUN` on the first `bck_en` that finds data, or finds halting deselected.
- `S_HALT` → `S_IDLE` when `tx_start` drops.

Top module: `i2s_tx_serializer`

## Requirements
- R1: After `rst_n` low or a cycle with `tx_rst` high, the block is in `S_IDLE` with `sd_out`=0, `ws_out`=0, `sclk_run`=0, and the FIFO is empty. `s_ready` is low during `tx_rst` and high otherwise, unless the FIFO is full.
- R2: A frame is 2*`SLOT_BITS` bit periods, and the outputs advance once per `bck_en` cycle in `S_RUN`. Let w = min(`cfg_bits`, `SLOT_BITS`) and d = the MSB delay, 0 or 1. At slot position p, `sd_out` carries sample bit w-1-(p-d) when 0 <= p-d < w. Every other position is low, and a width of 0 sends only zeros.
- R3: With `cfg_msb_delay`=1, the MSB appears at slot position 1, one bit period after the word-select change. With 0, it appears at slot position 0.
- R4: With `cfg_pulse_sync`=0, `ws_out` is 0 throughout the first slot and 1 throughout the second.
- R5: With `cfg_pulse_sync`=1, `ws_out` is 1 only during frame position 0.
- R6: With `cfg_right_first`=1, the first slot carries the right-channel data. With 0, the left channel goes first.
- R7: `cfg_chan_mode` selects the slot contents:
  - 0: both channels.
  - 1: right data only; the left slot is zero.
  - 2: left data only; the right slot is zero.
  - 3: the right sample in both slots.
  - 4: the left sample in both slots.
  - 5 to 7: treated as 0.
- R8: A sample pair is read from the FIFO only at frame position 0. The option inputs are captured at the same point and stay fixed for the whole frame.
- R9: With `cfg_stop_on_empty`=1, a frame start with an empty FIFO moves the block to `S_HALT`. There `sclk_run`, `sd_out` and `ws_out` are 0 and the position is held. The frame starts on the first later `bck_en` that finds data.
- R10: With `cfg_stop_on_empty`=0, a frame start with an empty FIFO sends a full frame of zero data with normal word select, and no data is consumed.
- R11: The FIFO holds `FIFO_DEPTH` pairs in arrival order. `s_ready` is low when it is full.
- R12: `fifo_pack_code` is {`cfg_bits` > `PACK_SPLIT`, `cfg_chan_mode` is 3 or 4}, giving codes 0/1 for narrow channels and 2/3 for wide channels, with the low bit set for mono.
- R13: Dropping `tx_start` in `S_RUN` or `S_HALT` returns the block to `S_IDLE` at the next edge with outputs low. The FIFO contents are kept, and the next start begins at frame position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_rst | input | 1 | Synchronous transmit reset; also flushes the FIFO |
| tx_start | input | 1 | Shifting enabled while high |
| bck_en | input | 1 | One-cycle bit-clock enable; one bit per pulse |
| cfg_right_first | input | 1 | Right channel in the first slot |
| cfg_msb_delay | input | 1 | Delay the MSB by one bit period |
| cfg_pulse_sync | input | 1 | One-bit frame-sync pulse instead of a level |
| cfg_chan_mode | input | 3 | Channel/slot mode, 0 to 4 |
| cfg_bits | input | BITS_W | Sample width in bits |
| cfg_stop_on_empty | input | 1 | Halt the bus when the FIFO is empty |
| s_valid | input | 1 | Sample pair valid |
| s_ready | output | 1 | FIFO accepts a pair |
| s_left | input | SLOT_BITS | Left sample, right-aligned |
| s_right | input | SLOT_BITS | Right sample, right-aligned |
| sd_out | output | 1 | Serial data |
| ws_out | output | 1 | Word select / frame sync |
| sclk_run | output | 1 | Bit clock should run |
| fifo_pack_code | output | 2 | FIFO packing code for the current settings |

## Verification
The following are checked on every cycle:
- the FIFO never holds more than its depth;
- reads happen only at a frame start;
- the sync pulse lasts exactly one position;
- entry into the halt state occurs only from an empty FIFO at frame position 0;
- the outputs are quiet outside `S_RUN`;
- dropping the start level sends the block to idle.

The bench scenarios show the following:
- the bit placement for each width, delay, channel order and channel mode, checked against a model of the frame on every bit;
- that option changes wait for a frame boundary;
- the order of the FIFO contents;
- zero-fill versus halting on underflow.

// File: rtl/i2s_tx_pkg.sv
`timescale 1ns/1ps
package i2s_tx_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_HALT = 2'd2
    } tx_state_e;

    localparam logic [2:0] CM_BOTH       = 3'd0;
    localparam logic [2:0] CM_RIGHT_ONLY = 3'd1;
    localparam logic [2:0] CM_LEFT_ONLY  = 3'd2;
    localparam logic [2:0] CM_DUP_RIGHT  = 3'd3;
    localparam logic [2:0] CM_DUP_LEFT   = 3'd4;

    typedef struct packed {
        logic       right_first;
        logic       msb_delay;
        logic       pulse_sync;
        logic [2:0] chan_mode;
    } frame_opts_t;

endpackage

// File: rtl/i2s_tx_fifo.sv
`timescale 1ns/1ps
module i2s_tx_fifo #(
    parameter int DW    = 64,
    parameter int DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         push,
    input  logic [DW-1:0]                din,
    input  logic                         pop,
    output logic [DW-1:0]                dout,
    output logic                         full,
    output logic                         empty,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt_q;
    logic          do_push, do_pop;

    assign full    = (cnt_q == FULL_CNT);
    assign empty   = (cnt_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];
    assign count   = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wr_ptr] <= din;
    end

endmodule

// File: rtl/i2s_tx_bit_sel.sv
`timescale 1ns/1ps
module i2s_tx_bit_sel
    import i2s_tx_pkg::*;
#(
    parameter int SLOT_BITS = 32,
    parameter int BITS_W    = 6,
    parameter int POS_W     = 6
) (
    input  logic [POS_W-1:0]     pos,
    input  frame_opts_t          opts,
    input  logic [BITS_W-1:0]    bits,
    input  logic [SLOT_BITS-1:0] left,
    input  logic [SLOT_BITS-1:0] right,
    output logic                 sd_bit,
    output logic                 ws_bit
);
    localparam logic [POS_W-1:0] SLOT_C = POS_W'(SLOT_BITS);

    logic                 second_slot;
    logic [POS_W-1:0]     slot_pos;
    logic [POS_W-1:0]     width;
    logic [POS_W-1:0]     k;
    logic                 in_range;
    logic                 ch_right;
    logic [SLOT_BITS-1:0] sample;
    logic [SLOT_BITS-1:0] shifted;

    always_comb begin
        second_slot = (pos >= SLOT_C);
        slot_pos    = second_slot ? (pos - SLOT_C) : pos;
        width       = (POS_W'(bits) > SLOT_C) ? SLOT_C : POS_W'(bits);
        ch_right    = second_slot ^ opts.right_first;

        unique case (opts.chan_mode)
            CM_RIGHT_ONLY: sample = ch_right ? right : '0;
            CM_LEFT_ONLY:  sample = ch_right ? '0 : left;
            CM_DUP_RIGHT:  sample = right;
            CM_DUP_LEFT:   sample = left;
            default:       sample = ch_right ? right : left;
        endcase

        if (opts.msb_delay && slot_pos == '0) begin
            k        = '0;
            in_range = 1'b0;
        end else begin
            k        = slot_pos - POS_W'(opts.msb_delay);
            in_range = (k < width);
        end

        shifted = sample >> (width - 1'b1 - k);
        sd_bit  = in_range && shifted[0];
        ws_bit  = opts.pulse_sync ? (pos == '0) : second_slot;
    end

endmodule

// File: rtl/i2s_tx_frame_ctl.sv
`timescale 1ns/1ps
module i2s_tx_frame_ctl
    import i2s_tx_pkg::*;
#(
    parameter int SLOT_BITS = 32,
    parameter int BITS_W    = 6,
    parameter int POS_W     = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tx_rst,
    input  logic                 tx_start,
    input  logic                 bck_en,
    input  logic                 stop_on_empty,
    input  frame_opts_t          live_opts,
    input  logic [BITS_W-1:0]    live_bits,
    input  logic                 fifo_empty,
    input  logic [SLOT_BITS-1:0] fifo_left,
    input  logic [SLOT_BITS-1:0] fifo_right,
    output logic                 fifo_pop,
    output logic [POS_W-1:0]     sel_pos,
    output frame_opts_t          sel_opts,
    output logic [BITS_W-1:0]    sel_bits,
    output logic [SLOT_BITS-1:0] sel_left,
    output logic [SLOT_BITS-1:0] sel_right,
    input  logic                 sd_bit,
    input  logic                 ws_bit,
    output logic                 sd_out,
    output logic                 ws_out,
    output logic                 sclk_run,
    output tx_state_e            state_o,
    output logic [POS_W-1:0]     pos_o,
    output frame_opts_t          snap_o
);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(2 * SLOT_BITS - 1);

    tx_state_e            state_q, state_d;
    logic [POS_W-1:0]     pos_q;
    frame_opts_t          snap_opts_q;
    logic [BITS_W-1:0]    snap_bits_q;
    logic [SLOT_BITS-1:0] hold_l_q, hold_r_q;
    logic                 sd_q, ws_q;

    logic frame_edge, take, park, emit, leave;

    // Decisions and next state
    always_comb begin
        frame_edge = bck_en && tx_start &&
                     ((state_q == S_HALT) || (state_q == S_RUN && pos_q == '0));
        take  = frame_edge && !fifo_empty;
        park  = frame_edge && fifo_empty && stop_on_empty;
        emit  = bck_en && tx_start && (state_q != S_IDLE) && !park;
        leave = !tx_start && (state_q != S_IDLE);

        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (tx_start) state_d = S_RUN;
            S_RUN: begin
                if (!tx_start)  state_d = S_IDLE;
                else if (park)  state_d = S_HALT;
            end
            S_HALT: begin
                if (!tx_start)                state_d = S_IDLE;
                else if (frame_edge && !park) state_d = S_RUN;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      state_q <= S_IDLE;
        else if (tx_rst) state_q <= S_IDLE;
        else             state_q <= state_d;
    end

    // Selection feeding the bit selector
    always_comb begin
        sel_pos   = pos_q;
        sel_opts  = frame_edge ? live_opts : snap_opts_q;
        sel_bits  = frame_edge ? live_bits : snap_bits_q;
        sel_left  = take ? fifo_left  : (frame_edge ? '0 : hold_l_q);
        sel_right = take ? fifo_right : (frame_edge ? '0 : hold_r_q);
    end

    // Position, frame snapshot and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q       <= '0;
            snap_opts_q <= '0;
            snap_bits_q <= '0;
            hold_l_q    <= '0;
            hold_r_q    <= '0;
            sd_q        <= 1'b0;
            ws_q        <= 1'b0;
        end else if (tx_rst || leave) begin
            pos_q       <= '0;
            snap_opts_q <= '0;
            snap_bits_q <= '0;
            hold_l_q    <= '0;
            hold_r_q    <= '0;
            sd_q        <= 1'b0;
            ws_q        <= 1'b0;
        end else if (emit) begin
            sd_q  <= sd_bit;
            ws_q  <= ws_bit;
            pos_q <= (pos_q == LAST_POS) ? '0 : pos_q + 1'b1;
            if (frame_edge) begin
                snap_opts_q <= live_opts;
                snap_bits_q <= live_bits;
                hold_l_q    <= sel_left;
                hold_r_q    <= sel_right;
            end
        end else if (park) begin
            sd_q <= 1'b0;
            ws_q <= 1'b0;
        end
    end

    assign fifo_pop = take;
    assign sd_out   = sd_q;
    assign ws_out   = ws_q;
    assign sclk_run = (state_q == S_RUN);
    assign state_o  = state_q;
    assign pos_o    = pos_q;
    assign snap_o   = snap_opts_q;

endmodule

// File: rtl/i2s_tx_serializer.sv
`timescale 1ns/1ps
module i2s_tx_serializer
    import i2s_tx_pkg::*;
#(
    parameter int SLOT_BITS  = 32,
    parameter int FIFO_DEPTH = 4,
    parameter int PACK_SPLIT = 16
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               tx_rst,
    input  logic                               tx_start,
    input  logic                               bck_en,
    input  logic                               cfg_right_first,
    input  logic                               cfg_msb_delay,
    input  logic                               cfg_pulse_sync,
    input  logic [2:0]                         cfg_chan_mode,
    input  logic [$clog2(SLOT_BITS+1)-1:0]     cfg_bits,
    input  logic                               cfg_stop_on_empty,
    input  logic                               s_valid,
    output logic                               s_ready,
    input  logic [SLOT_BITS-1:0]               s_left,
    input  logic [SLOT_BITS-1:0]               s_right,
    output logic                               sd_out,
    output logic                               ws_out,
    output logic                               sclk_run,
    output logic [1:0]                         fifo_pack_code
);
    localparam int BITS_W = $clog2(SLOT_BITS + 1);
    localparam int POS_W  = $clog2(2 * SLOT_BITS);
    localparam int CNT_W  = $clog2(FIFO_DEPTH + 1);
    localparam int PAIR_W = 2 * SLOT_BITS;

    frame_opts_t          live_opts, sel_opts, snap_opts;
    logic                 fifo_full, fifo_empty, fifo_pop, fifo_push;
    logic [CNT_W-1:0]     fifo_cnt;
    logic [PAIR_W-1:0]    fifo_head;
    logic [POS_W-1:0]     sel_pos, pos;
    logic [BITS_W-1:0]    sel_bits;
    logic [SLOT_BITS-1:0] sel_left, sel_right;
    logic                 sd_bit, ws_bit;
    tx_state_e            state;

    assign live_opts = '{right_first: cfg_right_first,
                         msb_delay:   cfg_msb_delay,
                         pulse_sync:  cfg_pulse_sync,
                         chan_mode:   cfg_chan_mode};

    assign s_ready   = !fifo_full && !tx_rst;
    assign fifo_push = s_valid && s_ready;

    assign fifo_pack_code = {(cfg_bits > BITS_W'(PACK_SPLIT)),
                             (cfg_chan_mode == CM_DUP_RIGHT) || (cfg_chan_mode == CM_DUP_LEFT)};

    i2s_tx_fifo #(.DW(PAIR_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (tx_rst),
        .push  (fifo_push),
        .din   ({s_left, s_right}),
        .pop   (fifo_pop),
        .dout  (fifo_head),
        .full  (fifo_full),
        .empty (fifo_empty),
        .count (fifo_cnt)
    );

    i2s_tx_frame_ctl #(.SLOT_BITS(SLOT_BITS), .BITS_W(BITS_W), .POS_W(POS_W)) u_ctl (
        .clk           (clk),
        .rst_n         (rst_n),
        .tx_rst        (tx_rst),
        .tx_start      (tx_start),
        .bck_en        (bck_en),
        .stop_on_empty (cfg_stop_on_empty),
        .live_opts     (live_opts),
        .live_bits     (cfg_bits),
        .fifo_empty    (fifo_empty),
        .fifo_left     (fifo_head[PAIR_W-1:SLOT_BITS]),
        .fifo_right    (fifo_head[SLOT_BITS-1:0]),
        .fifo_pop      (fifo_pop),
        .sel_pos       (sel_pos),
        .sel_opts      (sel_opts),
        .sel_bits      (sel_bits),
        .sel_left      (sel_left),
        .sel_right     (sel_right),
        .sd_bit        (sd_bit),
        .ws_bit        (ws_bit),
        .sd_out        (sd_out),
        .ws_out        (ws_out),
        .sclk_run      (sclk_run),
        .state_o       (state),
        .pos_o         (pos),
        .snap_o        (snap_opts)
    );

    i2s_tx_bit_sel #(.SLOT_BITS(SLOT_BITS), .BITS_W(BITS_W), .POS_W(POS_W)) u_bits (
        .pos    (sel_pos),
        .opts   (sel_opts),
        .bits   (sel_bits),
        .left   (sel_left),
        .right  (sel_right),
        .sd_bit (sd_bit),
        .ws_bit (ws_bit)
    );

endmodule

// File: rtl/i2s_tx_serializer_chk.sv
`timescale 1ns/1ps
module i2s_tx_serializer_chk
    import i2s_tx_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int POS_W      = 6,
    parameter int CNT_W      = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tx_rst,
    input logic             tx_start,
    input tx_state_e        state,
    input logic [POS_W-1:0] pos,
    input logic [CNT_W-1:0] fifo_cnt,
    input logic             fifo_pop,
    input frame_opts_t      snap_opts,
    input logic             sd_out,
    input logic             ws_out
);
    AST_QUIET_OUTSIDE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_RUN) |-> (!sd_out && !ws_out)); // R1

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= CNT_W'(FIFO_DEPTH)); // R11

    AST_POP_AT_FRAME_START: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_pop && !tx_rst) |=> (state == S_RUN && pos == POS_W'(1))); // R8

    AST_SYNC_PULSE_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RUN && snap_opts.pulse_sync && ws_out) |-> pos == POS_W'(1)); // R5

    AST_HALT_ONLY_WHEN_DRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_HALT && $past(state) != S_HALT) |-> (pos == '0 && $past(fifo_cnt) == '0)); // R9

    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_start && !tx_rst && state != S_IDLE) |=> (state == S_IDLE && pos == '0)); // R13

endmodule

bind i2s_tx_serializer i2s_tx_serializer_chk #(
    .FIFO_DEPTH (FIFO_DEPTH),
    .POS_W      ($clog2(2 * SLOT_BITS)),
    .CNT_W      ($clog2(FIFO_DEPTH + 1))
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_rst    (tx_rst),
    .tx_start  (tx_start),
    .state     (state),
    .pos       (pos),
    .fifo_cnt  (fifo_cnt),
    .fifo_pop  (fifo_pop),
    .snap_opts (snap_opts),
    .sd_out    (sd_out),
    .ws_out    (ws_out)
);

// File: tb/i2s_tx_serializer_tb_top.sv
`timescale 1ns/1ps
module i2s_tx_serializer_tb_top;
    localparam int SB    = 32;
    localparam int DEPTH = 4;
    localparam int SPLIT = 16;
    localparam int BW    = $clog2(SB + 1);
    localparam int FR    = 2 * SB;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst_n = 1'b0, tx_rst = 1'b0, tx_start = 1'b0, bck_en = 1'b0;
    logic          cfg_right_first = 1'b0, cfg_msb_delay = 1'b0, cfg_pulse_sync = 1'b0;
    logic [2:0]    cfg_chan_mode = 3'd0;
    logic [BW-1:0] cfg_bits = BW'(16);
    logic          cfg_stop_on_empty = 1'b0;
    logic          s_valid = 1'b0;
    logic [SB-1:0] s_left = '0, s_right = '0;
    logic          s_ready, sd_out, ws_out, sclk_run;
    logic [1:0]    fifo_pack_code;

    i2s_tx_serializer #(.SLOT_BITS(SB), .FIFO_DEPTH(DEPTH), .PACK_SPLIT(SPLIT)) dut_i (
        .clk(clk), .rst_n(rst_n), .tx_rst(tx_rst), .tx_start(tx_start), .bck_en(bck_en),
        .cfg_right_first(cfg_right_first), .cfg_msb_delay(cfg_msb_delay),
        .cfg_pulse_sync(cfg_pulse_sync), .cfg_chan_mode(cfg_chan_mode), .cfg_bits(cfg_bits),
        .cfg_stop_on_empty(cfg_stop_on_empty), .s_valid(s_valid), .s_ready(s_ready),
        .s_left(s_left), .s_right(s_right), .sd_out(sd_out), .ws_out(ws_out),
        .sclk_run(sclk_run), .fifo_pack_code(fifo_pack_code)
    );

    int n_cmp = 0, n_bad = 0;
    bit chk_en = 1'b0, done = 1'b0;

    // Reference model state (0 idle, 1 run, 2 halt)
    int          m_state = 0, m_pos = 0, m_cnt = 0;
    bit          m_sd = 0, m_ws = 0, m_zero = 0;
    bit          m_rf = 0, m_sh = 0, m_ps = 0;
    int          m_mode = 0, m_bits = 0;
    logic [SB-1:0] m_hl = '0, m_hr = '0;
    logic [SB-1:0] m_ql [DEPTH];
    logic [SB-1:0] m_qr [DEPTH];

    function automatic bit exp_sd(int pos, bit rf, bit sh, int mode, int bits,
                                  logic [SB-1:0] l, logic [SB-1:0] r);
        int slot_b = pos % SB;
        bit is_r = ((pos >= SB) ? 1'b1 : 1'b0) ^ rf;
        logic [SB-1:0] smp;
        int w = (bits > SB) ? SB : bits;
        int k = slot_b - int'(sh);
        case (mode)
            1: smp = is_r ? r : '0;
            2: smp = is_r ? '0 : l;
            3: smp = r;
            4: smp = l;
            default: smp = is_r ? r : l;
        endcase
        if (k < 0 || k >= w) return 1'b0;
        return smp[w - 1 - k];
    endfunction

    function automatic string sd_tag();
        if (m_zero) return "R10";
        if (m_mode >= 1 && m_mode <= 4) return "R7";
        if (m_sh) return "R3";
        if (m_rf) return "R6";
        return "R2";
    endfunction

    task automatic emit();
        m_sd = exp_sd(m_pos, m_rf, m_sh, m_mode, m_bits, m_hl, m_hr);
        m_ws = m_ps ? (m_pos == 0) : (m_pos >= SB);
        m_pos = (m_pos + 1) % FR;
    endtask

    task automatic snap_cfg();
        m_rf = cfg_right_first; m_sh = cfg_msb_delay; m_ps = cfg_pulse_sync;
        m_mode = int'(cfg_chan_mode); m_bits = int'(cfg_bits);
    endtask

    always @(posedge clk) begin
        bit can_push;
        can_push = s_valid && (m_cnt < DEPTH) && !tx_rst;
        if (!rst_n || tx_rst) begin
            m_state = 0; m_pos = 0; m_cnt = 0; m_sd = 0; m_ws = 0;
        end else begin
            case (m_state)
                0: if (tx_start) m_state = 1;
                default: begin
                    if (!tx_start) begin
                        m_state = 0; m_pos = 0; m_sd = 0; m_ws = 0;
                    end else if (bck_en) begin
                        if (m_state == 2 || m_pos == 0) begin
                            if (m_cnt > 0) begin
                                snap_cfg(); m_hl = m_ql[0]; m_hr = m_qr[0]; m_zero = 0;
                                for (int i = 0; i < DEPTH - 1; i++) begin
                                    m_ql[i] = m_ql[i+1]; m_qr[i] = m_qr[i+1];
                                end
                                m_cnt--; m_state = 1; emit();
                            end else if (cfg_stop_on_empty) begin
                                m_state = 2; m_sd = 0; m_ws = 0;
                            end else begin
                                snap_cfg(); m_hl = '0; m_hr = '0; m_zero = 1;
                                m_state = 1; emit();
                            end
                        end else emit();
                    end
                end
            endcase
            if (can_push) begin
                m_ql[m_cnt] = s_left; m_qr[m_cnt] = s_right; m_cnt++;
            end
        end
    end

    task automatic cmp(string tag, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        if (chk_en) begin
            cmp(sd_tag(), "sd_out", int'(sd_out), int'(m_sd));
            cmp(m_ps ? "R5" : "R4", "ws_out", int'(ws_out), int'(m_ws));
            cmp(tx_start ? "R9" : "R13", "sclk_run", int'(sclk_run), int'(m_state == 1));
            cmp("R11", "s_ready", int'(s_ready), int'((m_cnt < DEPTH) && !tx_rst));
        end
    endtask

    task automatic rand_cfg();
        cfg_right_first   = 1'($urandom_range(0, 1));
        cfg_msb_delay     = 1'($urandom_range(0, 1));
        cfg_pulse_sync    = 1'($urandom_range(0, 1));
        cfg_chan_mode     = 3'($urandom_range(0, 7));
        cfg_bits          = BW'($urandom_range(0, SB + 3));
        cfg_stop_on_empty = 1'($urandom_range(0, 1));
    endtask

    task automatic drive_push(int pct);
        s_valid = ($urandom_range(0, 99) < pct);
        s_left  = $urandom();
        s_right = $urandom();
    endtask

    initial begin : watchdog
        #(190000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h1F2E3D4C);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        // R1: reset state
        cmp("R1", "sd_out after reset", int'(sd_out), 0);
        cmp("R1", "ws_out after reset", int'(ws_out), 0);
        cmp("R1", "sclk_run after reset", int'(sclk_run), 0);
        cmp("R1", "s_ready after reset", int'(s_ready), 1);
        chk_en = 1'b1;

        // R12: packing code for several width/mode combinations
        for (int i = 0; i < 12; i++) begin
            cfg_bits      = BW'($urandom_range(0, SB));
            cfg_chan_mode = 3'($urandom_range(0, 7));
            if (i == 0) begin cfg_bits = BW'(SPLIT);     cfg_chan_mode = 3'd0; end
            if (i == 1) begin cfg_bits = BW'(SPLIT + 1); cfg_chan_mode = 3'd3; end
            if (i == 2) begin cfg_bits = BW'(8);         cfg_chan_mode = 3'd4; end
            tick();
            cmp("R12", "fifo_pack_code", int'(fifo_pack_code),
                int'({cfg_bits > BW'(SPLIT), (cfg_chan_mode == 3'd3 || cfg_chan_mode == 3'd4)}));
        end

        // R11: fill while idle, then check ready low; order checked by the bit stream
        cfg_chan_mode = 3'd0; cfg_bits = BW'(24); cfg_stop_on_empty = 1'b1;
        cfg_right_first = 1'b0; cfg_msb_delay = 1'b1; cfg_pulse_sync = 1'b0;
        for (int i = 0; i < DEPTH + 2; i++) begin drive_push(100); tick(); end
        s_valid = 1'b0;
        tick();
        cmp("R11", "s_ready when full", int'(s_ready), 0);

        // R9: drain with stop-on-empty so the bus halts
        tx_start = 1'b1;
        for (int c = 0; c < (DEPTH + 2) * FR * 2; c++) begin
            bck_en = ~bck_en; tick();
        end
        cmp("R9", "sclk_run halted on empty", int'(sclk_run), 0);

        // R10: zero frames without halting
        cfg_stop_on_empty = 1'b0;
        for (int c = 0; c < FR * 3; c++) begin bck_en = 1'b1; tick(); end

        // R1: transmit reset flushes a partly filled FIFO
        for (int i = 0; i < 2; i++) begin drive_push(100); tick(); end
        s_valid = 1'b0; tx_rst = 1'b1; tick(); tx_rst = 1'b0; tick();
        cmp("R1", "s_ready after tx_rst", int'(s_ready), 1);
        cmp("R1", "sclk_run after tx_rst", int'(sclk_run), 1);

        // Random phases: R2-R8, R13 mixed, option changes mid-frame (R8)
        for (int ph = 0; ph < 110; ph++) begin
            int pct, len;
            rand_cfg();
            pct = (ph % 4 == 0) ? 2 : 40;
            len = $urandom_range(200, 500);
            tx_start = 1'b1;
            for (int c = 0; c < len; c++) begin
                bck_en = ($urandom_range(0, 2) != 0);
                drive_push(pct);
                if ($urandom_range(0, 199) == 0) rand_cfg();
                tx_start = ($urandom_range(0, 299) != 0);
                tx_rst   = ($urandom_range(0, 999) == 0);
                tick();
            end
        end
        tx_rst = 1'b0; s_valid = 1'b0;

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule